// File: doc/BRIEF.md
# Video word clip and blank pipeline

This block is one processing stage in a 10-bit serial-digital video datapath. Each clock it may accept one word, marked by a valid strobe, along with per-word side information:

- the video standard in use;
- whether the word lies in the active picture;
- a per-word blank request;
- the timing reference that a flywheel generator supplies elsewhere, which is a pulse on the word where a timing reference sequence (TRS) should start, plus the XYZ word for that sequence.

The block applies its operations in a fixed order:

1. It overwrites timing reference sequences that turn up where the flywheel does not expect them.
2. It folds reserved code values inside the active picture into the legal range.
3. It forces requested words to the blanking level of the selected standard.
4. It writes a fresh TRS over the positions the flywheel does expect.

Because insertion comes last, a stream that is blanked from end to end still carries correct timing references.

A TRS in the data is recognised as three consecutive valid words 0x3FF, 0x000, 0x000 together with the next valid word. The flywheel position covers the valid word that carries the start pulse and the three valid words after it. A two-bit word phase (0 = Cb, 1 = Y, 2 = Cr, 3 = Y or alpha) advances on every valid word. It restarts at 0 on the word that follows the last word of a flywheel TRS.

Top module: `vwp_clipblank`

## Requirements
- R1: `out_vld` repeats `in_vld` exactly four clock cycles later. A valid output word is the result of the input word accepted four cycles earlier, passed through unchanged when no operation applies.
- R2: While `rst` is high at a clock edge, the outputs are cleared to `out_vld` = 0 and `out_word` = 0.
- R3: With `clip_en` high and `in_active` high, an input of 0x000–0x003 leaves as 0x004, and an input of 0x3FC–0x3FF leaves as 0x3FB.
- R4: Reserved values pass unchanged when `in_active` is low or `clip_en` is low.
- R5: A word taken with `in_blank_n` low leaves as the blanking level. For `in_std` = 0 (4:2:2 component) that level is 0x200 on phases 0 and 2, and 0x040 on phases 1 and 3.
- R6: The blanking level is 0x0F0 for `in_std` = 1 (NTSC composite) and 0x100 for `in_std` = 2 (PAL composite), whatever the phase.
- R7: The blanking level is 0x040 on every phase for `in_std` = 3 (4:4:4:4 RGB plus alpha). For `in_std` = 4 (4:4:4:4 YCbCr plus alpha), it is 0x200 on phases 0 and 2 and 0x040 on phases 1 and 3. Codes 5 to 7 blank like code 0.
- R8: The phase restarts at 0 (Cb) on the valid word after the fourth word of a flywheel TRS. Without a restart, it counts modulo 4 over valid words.
- R9: With `trs_blank_en` and `fw_en` both high, every word of a detected TRS that is not at a flywheel position becomes the blanking level. A TRS that is at the flywheel positions is left alone.
- R10: With `fw_en` low, misplaced TRS words are not blanked, even when `trs_blank_en` is high.
- R11: With `trs_ins_en` high, the four flywheel positions leave as 0x3FF, 0x000, 0x000 and the `fw_xyz` value taken with the fourth word. This overrides clipping and blanking.
- R12: TRS blanking acts before clipping. A misplaced TRS in the active picture therefore leaves as the blanking level, not as the clipped values 0x3FB/0x004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input word strobe |
| in_word | input | WORD_W | Input video word |
| in_std | input | 3 | Video standard code (0..4, see R5 to R7) |
| in_active | input | 1 | Word lies in the active picture |
| in_blank_n | input | 1 | Per-word blank request, active low |
| fw_en | input | 1 | Flywheel enable; when low, TRS blanking is off |
| fw_trs_start | input | 1 | Flywheel pulse on the word where a TRS should start |
| fw_xyz | input | WORD_W | XYZ word to insert as the fourth TRS word |
| trs_blank_en | input | 1 | Enable blanking of misplaced TRS words |
| clip_en | input | 1 | Enable reserved-code clipping in the active picture |
| trs_ins_en | input | 1 | Enable TRS insertion at flywheel positions |
| out_vld | output | 1 | Output word strobe |
| out_word | output | WORD_W | Processed video word |

## Verification
A word phase that has drifted shows up as 0x200 and 0x040 swapped on the next blanked 4:2:2 or YCbCr+alpha word. This becomes visible four cycles after that word enters. A lost pending TRS mark leaves the fourth word of a misplaced sequence unblanked. A stale mark blanks an innocent data word. Either fault appears within four cycles of the pattern's last word. A flywheel position counter that is off by one moves the inserted 0x3FF/0x000/0x000/XYZ onto the wrong words. That error is seen in the very first line.

// File: rtl/vwp_pkg.sv
package vwp_pkg;

   localparam int VW      = 10;
   localparam int TRS_LEN = 4;

   localparam logic [2:0] STD_CMP   = 3'd0;
   localparam logic [2:0] STD_NTSC  = 3'd1;
   localparam logic [2:0] STD_PAL   = 3'd2;
   localparam logic [2:0] STD_RGBA  = 3'd3;
   localparam logic [2:0] STD_YCCA  = 3'd4;

   localparam logic [VW-1:0] LVL_CHROMA = 10'h200;
   localparam logic [VW-1:0] LVL_LUMA   = 10'h040;
   localparam logic [VW-1:0] LVL_NTSC   = 10'h0F0;
   localparam logic [VW-1:0] LVL_PAL    = 10'h100;

   // Blanking level for a standard and word phase (phase bit 0 set = luma/alpha slot)
   function automatic logic [VW-1:0] blank_level(input logic [2:0] sd, input logic [1:0] ph);
      logic [VW-1:0] lv;
      case (sd)
         STD_NTSC: lv = LVL_NTSC;
         STD_PAL:  lv = LVL_PAL;
         STD_RGBA: lv = LVL_LUMA;
         default:  lv = ph[0] ? LVL_LUMA : LVL_CHROMA;
      endcase
      return lv;
   endfunction

endpackage

// File: rtl/vwp_tagger.sv
module vwp_tagger
   import vwp_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int PH_W  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vld,
   input  logic             start,
   output logic             exp,
   output logic [IDX_W-1:0] idx,
   output logic [PH_W-1:0]  ph
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(TRS_LEN - 1);

   logic             run_q;
   logic [IDX_W-1:0] nxt_q;
   logic [PH_W-1:0]  ph_q;

   always_comb begin
      exp = 1'b0;
      idx = '0;
      if (vld && start) begin
         exp = 1'b1;
      end else if (vld && run_q) begin
         exp = 1'b1;
         idx = nxt_q;
      end
      ph = ph_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         nxt_q <= '0;
         ph_q  <= '0;
      end else if (vld) begin
         if (exp && idx == LAST) begin
            run_q <= 1'b0;
            nxt_q <= '0;
            ph_q  <= '0;
         end else begin
            ph_q <= ph_q + 1'b1;
            if (exp) begin
               run_q <= 1'b1;
               nxt_q <= idx + 1'b1;
            end
         end
      end
   end

   // R8
   run_pos_chk: assert property (@(posedge clk) disable iff (rst)
      run_q |-> (nxt_q != '0));

endmodule

// File: rtl/vwp_trs_finder.sv
module vwp_trs_finder #(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_v,
   input  logic [WORD_W-1:0] in_w,
   input  logic              p1_v,
   input  logic [WORD_W-1:0] p1_w,
   input  logic              p2_v,
   input  logic [WORD_W-1:0] p2_w,
   output logic              det,
   output logic              mark_new
);
   localparam logic [WORD_W-1:0] ONES  = {WORD_W{1'b1}};
   localparam logic [WORD_W-1:0] ZEROS = '0;

   logic pend_q;

   assign det      = in_v && p1_v && p2_v && (p2_w == ONES) && (p1_w == ZEROS) && (in_w == ZEROS);
   assign mark_new = det || (pend_q && in_v);

   always_ff @(posedge clk) begin
      if (rst)       pend_q <= 1'b0;
      else if (det)  pend_q <= 1'b1;
      else if (in_v) pend_q <= 1'b0;
   end

   // R9
   pend_excl_chk: assert property (@(posedge clk) disable iff (rst)
      pend_q |-> !det);

endmodule

// File: rtl/vwp_word_op.sv
module vwp_word_op
   import vwp_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter int IDX_W  = 2,
   parameter int PH_W   = 2
) (
   input  logic [WORD_W-1:0] w,
   input  logic [WORD_W-1:0] xyz,
   input  logic [2:0]        sd,
   input  logic [PH_W-1:0]   ph,
   input  logic [IDX_W-1:0]  idx,
   input  logic              active,
   input  logic              blank_n,
   input  logic              exp,
   input  logic              trs,
   input  logic              tb_en,
   input  logic              clip_en,
   input  logic              ins_en,
   output logic [WORD_W-1:0] y
);
   localparam logic [WORD_W-1:0] ONES    = {WORD_W{1'b1}};
   localparam logic [WORD_W-1:0] CLIP_LO = WORD_W'(4);
   localparam logic [WORD_W-1:0] CLIP_HI = ONES - WORD_W'(4);

   logic [WORD_W-1:0] lvl, s_tb, s_cl, s_bk;

   always_comb begin
      lvl  = blank_level(sd, ph);
      s_tb = (tb_en && trs && !exp) ? lvl : w;
      s_cl = s_tb;
      if (clip_en && active) begin
         if (s_tb < CLIP_LO)      s_cl = CLIP_LO;
         else if (s_tb > CLIP_HI) s_cl = CLIP_HI;
      end
      s_bk = blank_n ? s_cl : lvl;
      y    = s_bk;
      if (ins_en && exp) begin
         case (idx)
            IDX_W'(0): y = ONES;
            IDX_W'(TRS_LEN - 1): y = xyz;
            default: y = '0;
         endcase
      end
   end

endmodule

// File: rtl/vwp_clipblank.sv
module vwp_clipblank
   import vwp_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [WORD_W-1:0] in_word,
   input  logic [2:0]        in_std,
   input  logic              in_active,
   input  logic              in_blank_n,
   input  logic              fw_en,
   input  logic              fw_trs_start,
   input  logic [WORD_W-1:0] fw_xyz,
   input  logic              trs_blank_en,
   input  logic              clip_en,
   input  logic              trs_ins_en,
   output logic              out_vld,
   output logic [WORD_W-1:0] out_word
);
   localparam int NSTG  = 3;
   localparam int LAT   = NSTG + 1;
   localparam int PH_W  = 2;
   localparam int IDX_W = $clog2(TRS_LEN);
   localparam int CYC_W = $clog2(LAT + 1);

   generate
      if (WORD_W != VW) begin : g_bad_width
         $error("vwp_clipblank: blanking levels are defined for %0d-bit words", VW);
      end
      if (TRS_LEN != 4) begin : g_bad_trs
         $error("vwp_clipblank: TRS length must be 4");
      end
      if (NSTG < 3) begin : g_bad_depth
         $error("vwp_clipblank: detection window needs three stages");
      end
   endgenerate

   typedef struct packed {
      logic              vld;
      logic [WORD_W-1:0] word;
      logic [WORD_W-1:0] xyz;
      logic [2:0]        sd;
      logic [PH_W-1:0]   ph;
      logic [IDX_W-1:0]  idx;
      logic              exp;
      logic              trs;
      logic              active;
      logic              blank_n;
      logic              tb_en;
      logic              clip_en;
      logic              ins_en;
   } stg_t;

   stg_t             head;
   stg_t             st [1:NSTG];
   logic             t_exp;
   logic [IDX_W-1:0] t_idx;
   logic [PH_W-1:0]  t_ph;
   logic             det, mark_new;
   logic [WORD_W-1:0] op_y;

   vwp_tagger #(.IDX_W(IDX_W), .PH_W(PH_W)) u_tag (
      .clk   (clk),
      .rst   (rst),
      .vld   (in_vld),
      .start (fw_trs_start),
      .exp   (t_exp),
      .idx   (t_idx),
      .ph    (t_ph)
   );

   vwp_trs_finder #(.WORD_W(WORD_W)) u_find (
      .clk      (clk),
      .rst      (rst),
      .in_v     (in_vld),
      .in_w     (in_word),
      .p1_v     (st[1].vld),
      .p1_w     (st[1].word),
      .p2_v     (st[2].vld),
      .p2_w     (st[2].word),
      .det      (det),
      .mark_new (mark_new)
   );

   always_comb begin
      head.vld     = in_vld;
      head.word    = in_word;
      head.xyz     = fw_xyz;
      head.sd      = in_std;
      head.ph      = t_ph;
      head.idx     = t_idx;
      head.exp     = t_exp;
      head.trs     = mark_new;
      head.active  = in_active;
      head.blank_n = in_blank_n;
      head.tb_en   = trs_blank_en && fw_en;
      head.clip_en = clip_en;
      head.ins_en  = trs_ins_en;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 1; k <= NSTG; k++) st[k] <= '0;
      end else begin
         st[1] <= head;
         for (int k = 2; k <= NSTG; k++) begin
            st[k]     <= st[k-1];
            st[k].trs <= st[k-1].trs || det;
         end
      end
   end

   vwp_word_op #(.WORD_W(WORD_W), .IDX_W(IDX_W), .PH_W(PH_W)) u_op (
      .w       (st[NSTG].word),
      .xyz     (st[NSTG].xyz),
      .sd      (st[NSTG].sd),
      .ph      (st[NSTG].ph),
      .idx     (st[NSTG].idx),
      .active  (st[NSTG].active),
      .blank_n (st[NSTG].blank_n),
      .exp     (st[NSTG].exp),
      .trs     (st[NSTG].trs),
      .tb_en   (st[NSTG].tb_en),
      .clip_en (st[NSTG].clip_en),
      .ins_en  (st[NSTG].ins_en),
      .y       (op_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld  <= st[NSTG].vld;
         out_word <= op_y;
      end
   end

   // ---------------- checks ----------------
   logic [CYC_W-1:0]  cyc_q;
   logic [WORD_W-1:0] lvl_chk;
   logic              ins_hit;

   always_ff @(posedge clk) begin
      if (rst)                   cyc_q <= '0;
      else if (cyc_q != CYC_W'(LAT)) cyc_q <= cyc_q + 1'b1;
   end

   assign lvl_chk = blank_level(st[NSTG].sd, st[NSTG].ph);
   assign ins_hit = st[NSTG].ins_en && st[NSTG].exp;

   // R1
   vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_q == CYC_W'(LAT)) |-> (out_vld == $past(in_vld, 4)));

   // R3
   clip_range_chk: assert property (@(posedge clk) disable iff (rst)
      (st[NSTG].vld && st[NSTG].clip_en && st[NSTG].active && !ins_hit)
      |=> (out_word >= WORD_W'(4)) && (out_word <= ({WORD_W{1'b1}} - WORD_W'(4))));

   // R5
   blank_level_chk: assert property (@(posedge clk) disable iff (rst)
      (st[NSTG].vld && !st[NSTG].blank_n && !ins_hit) |=> (out_word == $past(lvl_chk)));

   // R11
   ins_head_chk: assert property (@(posedge clk) disable iff (rst)
      (st[NSTG].vld && ins_hit && st[NSTG].idx == '0) |=> (out_word == {WORD_W{1'b1}}));

   // R11
   ins_xyz_chk: assert property (@(posedge clk) disable iff (rst)
      (st[NSTG].vld && ins_hit && st[NSTG].idx == IDX_W'(TRS_LEN - 1))
      |=> (out_word == $past(st[NSTG].xyz)));

endmodule

// File: tb/sim_vwp_clipblank.sv
module sim_vwp_clipblank;
   localparam int CLK_NS = 10;
   localparam int N      = 3072;
   localparam int LINE   = 64;
   localparam int SEG    = 256;

   logic clk = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic       rst, in_vld, in_active, in_blank_n, fw_en, fw_trs_start;
   logic       trs_blank_en, clip_en, trs_ins_en, out_vld;
   logic [9:0] in_word, fw_xyz, out_word;
   logic [2:0] in_std;

   vwp_clipblank u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word), .in_std(in_std),
      .in_active(in_active), .in_blank_n(in_blank_n), .fw_en(fw_en),
      .fw_trs_start(fw_trs_start), .fw_xyz(fw_xyz), .trs_blank_en(trs_blank_en),
      .clip_en(clip_en), .trs_ins_en(trs_ins_en), .out_vld(out_vld), .out_word(out_word)
   );

   logic       s_vld [N];
   logic [9:0] s_w   [N];
   logic [9:0] s_xyz [N];
   logic [2:0] s_std [N];
   logic       s_act [N], s_bn [N], s_fw [N], s_st [N], s_tb [N], s_cl [N], s_in [N];
   logic       e_vld [N];
   logic [9:0] e_w   [N];
   int         e_req [N];

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   function automatic logic [9:0] lvl_of(input logic [2:0] sd, input logic [1:0] p);
      if (sd == 3'd1) return 10'h0F0;
      if (sd == 3'd2) return 10'h100;
      if (sd == 3'd3) return 10'h040;
      return (p == 2'd1 || p == 2'd3) ? 10'h040 : 10'h200;
   endfunction

   function automatic logic [9:0] rnd_word();
      int r = $urandom % 8;
      if (r < 2) return 10'($urandom % 4);
      if (r < 4) return 10'h3FC + 10'($urandom % 4);
      return 10'($urandom);
   endfunction

   task automatic gen();
      logic [2:0] sd;
      logic tb, fw, cl, ins, allbk, mis, gaps, realtrs;
      int mp = 30;
      logic [9:0] xyz = 10'h200;
      for (int s = 0; s < N / SEG; s++) begin
         sd = 3'd0; tb = 0; fw = 1; cl = 0; ins = 0; allbk = 0; mis = 0; gaps = 0;
         case (s)
            0: ;                                              // R4 pass-through
            1: cl = 1;                                        // R3, R4
            2: begin allbk = 1; ins = 1; end                  // R5, R8, R11
            3: begin sd = 3'd1; ins = 1; end                  // R6
            4: begin sd = 3'd2; cl = 1; end                   // R6
            5: begin sd = 3'd3; ins = 1; end                  // R7
            6: begin sd = 3'd4; tb = 1; cl = 1; mis = 1; end  // R9, R12
            7: begin tb = 1; fw = 0; mis = 1; end             // R10
            default: begin
               sd = 3'($urandom); tb = 1'($urandom); fw = 1'($urandom);
               cl = 1'($urandom); ins = 1'($urandom); mis = 1'($urandom);
               gaps = 1'($urandom);
            end
         endcase
         realtrs = 1;
         for (int j = 0; j < SEG; j++) begin
            int i   = s * SEG + j;
            int pos = i % LINE;
            if (pos == 0) begin
               mp      = 20 + int'($urandom % 30);
               xyz     = {1'b1, 9'($urandom)};
               realtrs = (s < 8) || (($urandom % 4) != 0);
            end
            s_vld[i] = gaps ? (($urandom % 12) != 0) : 1'b1;
            s_w[i]   = rnd_word();
            if (realtrs && pos < 4)
               s_w[i] = (pos == 0) ? 10'h3FF : (pos == 3) ? xyz : 10'h000;
            if (mis && pos >= mp && pos < mp + 4)
               s_w[i] = (pos == mp) ? 10'h3FF : (pos == mp + 3) ? (xyz ^ 10'h004) : 10'h000;
            s_xyz[i] = xyz;
            s_st[i]  = (pos == 0);
            s_act[i] = (pos >= 8 && pos < 60);
            s_bn[i]  = allbk ? 1'b0 : (($urandom % 8) != 0);
            s_std[i] = sd; s_tb[i] = tb; s_fw[i] = fw; s_cl[i] = cl; s_in[i] = ins;
         end
      end
   endtask

   task automatic model();
      logic       run = 0, pend = 0, det, tbhit;
      logic [1:0] nxt = 0, ph = 0;
      logic       ex   [N];
      logic [1:0] ix   [N];
      logic [1:0] pa   [N];
      logic       mark [N];
      logic [9:0] w, lv;
      for (int i = 0; i < N; i++) begin
         // R8 flywheel positions and word phase
         ex[i] = 0; ix[i] = 0; pa[i] = ph; mark[i] = 0;
         if (s_vld[i]) begin
            if (s_st[i]) begin ex[i] = 1; ix[i] = 0; end
            else if (run) begin ex[i] = 1; ix[i] = nxt; end
            if (ex[i] && ix[i] == 2'd3) begin run = 0; ph = 0; end
            else begin
               ph = ph + 1'b1;
               if (ex[i]) begin run = 1; nxt = ix[i] + 1'b1; end
            end
         end
      end
      for (int i = 0; i < N; i++) begin
         // R9 detection of 3FF 000 000 plus the next valid word
         det = (i >= 2) && s_vld[i] && s_vld[i-1] && s_vld[i-2] &&
               s_w[i-2] == 10'h3FF && s_w[i-1] == 10'h000 && s_w[i] == 10'h000;
         if (det) begin mark[i-2] = 1; mark[i-1] = 1; mark[i] = 1; pend = 1; end
         else if (pend && s_vld[i]) begin mark[i] = 1; pend = 0; end
      end
      for (int i = 0; i < N; i++) begin
         lv    = lvl_of(s_std[i], pa[i]);
         tbhit = s_tb[i] && s_fw[i] && mark[i] && !ex[i];
         w     = tbhit ? lv : s_w[i];
         if (s_cl[i] && s_act[i]) begin
            if (w < 10'h004) w = 10'h004;
            else if (w > 10'h3FB) w = 10'h3FB;
         end
         if (!s_bn[i]) w = lv;
         if (s_in[i] && ex[i]) w = (ix[i] == 0) ? 10'h3FF : (ix[i] == 3) ? s_xyz[i] : 10'h000;
         e_vld[i] = s_vld[i];
         e_w[i]   = w;
         if (s_in[i] && ex[i]) e_req[i] = 11;
         else if (!s_bn[i]) begin
            if (s_std[i] == 3'd1 || s_std[i] == 3'd2) e_req[i] = 6;
            else if (s_std[i] == 3'd3) e_req[i] = 7;
            else if (pa[i] == 2'd0) e_req[i] = 8;
            else e_req[i] = (s_std[i] == 3'd0) ? 5 : 7;
         end
         else if (tbhit) e_req[i] = (s_cl[i] && s_act[i]) ? 12 : 9;   // R12 order
         else if (s_tb[i] && !s_fw[i] && mark[i] && !ex[i]) e_req[i] = 10;
         else if (s_cl[i] && s_act[i] && (s_w[i] < 10'h004 || s_w[i] > 10'h3FB)) e_req[i] = 3;
         else if (s_w[i] < 10'h004 || s_w[i] > 10'h3FB) e_req[i] = 4;
         else if (mark[i] && ex[i]) e_req[i] = 9;
         else e_req[i] = 1;
      end
   endtask

   task automatic drive(input int k);
      if (k < N) begin
         in_vld = s_vld[k]; in_word = s_w[k]; in_std = s_std[k]; in_active = s_act[k];
         in_blank_n = s_bn[k]; fw_en = s_fw[k]; fw_trs_start = s_st[k]; fw_xyz = s_xyz[k];
         trs_blank_en = s_tb[k]; clip_en = s_cl[k]; trs_ins_en = s_in[k];
      end else begin
         in_vld = 0; in_word = 0; in_std = 0; in_active = 0; in_blank_n = 1; fw_en = 0;
         fw_trs_start = 0; fw_xyz = 0; trs_blank_en = 0; clip_en = 0; trs_ins_en = 0;
      end
   endtask

   task automatic chk(input int k);
      total++;
      if (out_vld !== e_vld[k]) begin
         bad++;
         $display("FAIL R1 word %0d: out_vld got %b expected %b", k, out_vld, e_vld[k]);
      end
      if (e_vld[k]) begin
         total++;
         if (out_word !== e_w[k]) begin
            bad++;
            $display("FAIL R%0d word %0d: got %h expected %h", e_req[k], k, out_word, e_w[k]);
         end
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog: got running expected finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7351));
      gen();
      model();
      rst = 1'b1;
      drive(N);
      in_vld = 1'b1;
      repeat (5) @(negedge clk);
      // R2 reset state
      total++;
      if (out_vld !== 1'b0) begin bad++; $display("FAIL R2 reset: out_vld got %b expected 0", out_vld); end
      total++;
      if (out_word !== 10'h000) begin bad++; $display("FAIL R2 reset: out_word got %h expected 000", out_word); end
      rst = 1'b0;
      drive(0);
      for (int c = 1; c < N + 6; c++) begin
         @(negedge clk);
         if (c >= 4 && c - 4 < N) chk(c - 4);
         drive(c);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule